// File: doc/BRIEF.md
# Single-Bank Prioritised Interrupt Handler

This block gathers 32 interrupt request lines into one pending register and raises one of two outputs to the processor. One output is for the normal class and one is for the fast class. Each line has its own configuration word, set by software:
- a 5-bit priority,
- a choice between edge and level sensitivity,
- a class select.

A mask register blocks individual lines from arbitration. A single arbiter submodule finds the best unmasked pending line for each class.

When a class is armed and has a candidate, the handler latches the winning line number into that class's vector register and raises the class output. The output stays high and the vector stays frozen until software re-arms the class through the control register. Reading a vector register also acknowledges an edge-sensitive winner by clearing its pending bit. Software can inject an interrupt through a trigger register.

The register interface is a simple word-wide strobe interface. A request is sampled on a rising clock edge. The read data and the error flag are registered, so they are valid in the cycle after the request.

Top module: `irq_bank_ctrl`

## Requirements
- R1: Reset (synchronous, `rst_n` low) leaves the mask register all ones, and leaves pending, configuration words, input history and vectors at zero. Both class outputs are low and both classes are armed.
- R2: An edge-sensitive line (configuration bit 1 = 0) becomes pending only on a low-to-high change of its input. Its pending bit stays set when the input falls again.
- R3: A level-sensitive line (configuration bit 1 = 1) is pending while its input is high, and its pending bit clears one cycle after the input falls.
- R4: A write to the pending register (offset 0x00) ANDs the data into the pending bits. Bits of level-sensitive lines whose sampled input is high stay set regardless.
- R5: The configuration word of line n is at offset 0x1C + 4*n and holds priority in bits [6:2], sensitivity in bit 1 and class select in bit 0 (1 = fast). It reads back in the same layout, with all other bits reading as 0.
- R6: Among the pending lines that are unmasked (mask bit 0) and belong to a class, the lowest priority value wins. On equal priority the higher line number wins.
- R7: Fire and re-arm behave as follows:
  - Firing: while a class is armed and has a candidate, its output rises on the next clock and its vector register (normal 0x10, fast 0x14) latches the winner. The output then stays high and the vector holds.
  - Re-arming: a control write (offset 0x18) with bit 0 re-arms the normal class and with bit 1 re-arms the fast class. Either write drops the selected output on the same edge.
- R8: Reading a vector register returns the latched line number. If that line is edge-sensitive, the read clears its pending bit. A level-sensitive line's pending bit is left untouched.
- R9: A write to the trigger register (offset 0x9C) makes only the lowest-numbered set bit of the data pending. The trigger and control registers read as 0.
- R10: A write to the mask register (offset 0x04) replaces it and reads back unchanged. Masked lines never fire, and unmasking a pending line lets it fire.
- R11: An access to an undefined or misaligned offset behaves as follows:
  - a read returns 0;
  - a write changes nothing;
  - either raises the error flag for one cycle.
  
  A write to a vector register is ignored and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines, active high |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read |
| rsp_err | output | 1 | One-cycle pulse for an undefined or misaligned access |
| irq_norm_o | output | 1 | Normal-class interrupt output |
| irq_fast_o | output | 1 | Fast-class interrupt output |

## Verification
The embedded properties check the following on every cycle:
- a falling level input always clears its pending bit;
- edge pending bits fall only through a write or an acknowledge;
- a class fires only when armed and latches the arbiter's choice;
- a vector changes only at a firing;
- the arbiter's winner is always an unmasked pending line of the right class;
- an error pulse always carries zero read data.

Only the bench scenarios can show the ordering results and the read side effects. These include tie breaking by line number, the sequence of vectors delivered across repeated re-arms, and acknowledge on read for edge lines but not level lines. They also include the AND write with level protection, the lowest-bit trigger, and the register reset values after a mid-run reset.

// File: rtl/intc_pkg.sv
// Package: shared register offsets and class indices for the interrupt handler.
// Assumes an 8-bit byte address and word-aligned registers.
package intc_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_PEND     = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK     = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_VEC_NORM = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_VEC_FAST = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CFG_BASE = 8'h1C;

    // Class index doubles as the control-register re-arm bit position.
    localparam int NUM_CLASSES = 2;
    localparam int CLS_NORMAL  = 0;
    localparam int CLS_FAST    = 1;
endpackage

// File: rtl/intc_line_capture.sv
// Module: per-line capture of interrupt events into the pending register.
// Edge lines latch on a rising input, level lines follow their input.
// Assumes inputs are already synchronous to clk.
module intc_line_capture #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] level_i,
    input  logic                 pend_wr_i,
    input  logic [NUM_LINES-1:0] pend_wdata_i,
    input  logic [NUM_LINES-1:0] ack_mask_i,
    input  logic                 trig_i,
    input  logic [NUM_LINES-1:0] trig_bits_i,
    output logic [NUM_LINES-1:0] pending_o
);
    logic [NUM_LINES-1:0] hist_q;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] keep;
    logic [NUM_LINES-1:0] trig_one;
    logic [NUM_LINES-1:0] set_ev;
    logic [NUM_LINES-1:0] clr_ev;
    logic [NUM_LINES-1:0] pend_nxt;

    // Purpose: combine software writes, acknowledges and input events.
    always_comb begin
        keep     = pend_wr_i ? (pend_wdata_i | (level_i & hist_q)) : '1;
        trig_one = trig_i ? (trig_bits_i & (~trig_bits_i + NUM_LINES'(1))) : '0;
        set_ev   = (irq_in & ~hist_q & ~level_i) | (irq_in & level_i) | trig_one;
        clr_ev   = level_i & hist_q & ~irq_in;
        pend_nxt = ((pend_q & keep & ~ack_mask_i) | set_ev) & ~clr_ev;
    end

    // Purpose: register input history and pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            pend_q <= '0;
        end else begin
            hist_q <= irq_in;
            pend_q <= pend_nxt;
        end
    end

    assign pending_o = pend_q;

    // R3: a level line whose input fell is not pending afterwards.
    p_level_fall_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & $past(level_i & hist_q & ~irq_in)) == '0));

    // R2: edge pending bits drop only through a write or an acknowledge.
    p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_q & ~level_i & ~ack_mask_i & (pend_wr_i ? pend_wdata_i : '1))
          & ~pend_q) == '0));
endmodule

// File: rtl/intc_prio_arbiter.sv
// Module: finds, for each class, the best unmasked pending line.
// Lower priority value wins; on a tie the higher line number wins.
// Purely combinational; one result per class.
module intc_prio_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 5,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]              pending_i,
    input  logic [NUM_LINES-1:0]              mask_i,
    input  logic [NUM_LINES-1:0]              fast_i,
    input  logic [NUM_LINES*PRIO_W-1:0]       prio_i,
    output logic [NUM_CLASSES-1:0]            any_o,
    output logic [NUM_CLASSES-1:0][IDX_W-1:0] idx_o
);
    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        logic [NUM_LINES-1:0] cand;
        logic [PRIO_W-1:0]    best_p;
        logic [IDX_W-1:0]     best_i;
        logic                 found;

        assign cand = pending_i & ~mask_i & ((c == CLS_FAST) ? fast_i : ~fast_i);

        // Purpose: scan all candidates, keeping the best (ties go upward).
        always_comb begin
            best_p = '1;
            best_i = '0;
            found  = 1'b0;
            for (int i = 0; i < NUM_LINES; i++) begin
                if (cand[i] && (prio_i[i*PRIO_W +: PRIO_W] <= best_p)) begin
                    best_p = prio_i[i*PRIO_W +: PRIO_W];
                    best_i = IDX_W'(i);
                    found  = 1'b1;
                end
            end
        end

        assign any_o[c] = found;
        assign idx_o[c] = best_i;
    end
endmodule

// File: rtl/intc_class_ctrl.sv
// Module: fire/re-arm control and vector latch for one interrupt class.
// The class is armed while its output is low. It fires once on a candidate
// and holds until software re-arms it.
module intc_class_ctrl #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rearm_i,
    input  logic             cand_any_i,
    input  logic [IDX_W-1:0] cand_idx_i,
    output logic             irq_o,
    output logic [IDX_W-1:0] vec_o
);
    logic             irq_q;
    logic [IDX_W-1:0] vec_q;

    // Purpose: re-arm drops the output; an armed class latches a winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            vec_q <= '0;
        end else if (rearm_i) begin
            irq_q <= 1'b0;
        end else if (!irq_q && cand_any_i) begin
            irq_q <= 1'b1;
            vec_q <= cand_idx_i;
        end
    end

    assign irq_o = irq_q;
    assign vec_o = vec_q;

    // R7: an armed class with a candidate fires and latches that winner.
    p_fire_latches_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_q && cand_any_i && !rearm_i) |=> (irq_q && vec_q == $past(cand_idx_i)));

    // R7: the vector changes only at a firing.
    p_vec_only_on_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vec_q) |-> $rose(irq_q));

    // R7: re-arm drops the output on the following edge.
    p_rearm_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> !irq_q);
endmodule

// File: rtl/irq_bank_ctrl.sv
// Module: top of the single-bank interrupt handler. It holds:
//   - register decode and read side effects;
//   - configuration and mask storage;
//   - the capture, arbiter and per-class controllers.
// Assumes word accesses on a one-cycle strobe, with read data registered.
module irq_bank_ctrl
    import intc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [NUM_LINES-1:0] req_wdata,
    output logic [NUM_LINES-1:0] rsp_rdata,
    output logic                 rsp_err,
    output logic                 irq_norm_o,
    output logic                 irq_fast_o
);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam logic [ADDR_W-1:0] OFS_TRIG = ADDR_W'(int'(OFS_CFG_BASE) + 4 * NUM_LINES);

    logic [NUM_LINES-1:0]              mask_q;
    logic [NUM_LINES-1:0]              level_q;
    logic [NUM_LINES-1:0]              fast_q;
    logic [NUM_LINES*PRIO_W-1:0]       prio_q;
    logic [NUM_LINES-1:0]              pending;
    logic [NUM_CLASSES-1:0]            arb_any;
    logic [NUM_CLASSES-1:0][IDX_W-1:0] arb_idx;
    logic [NUM_CLASSES-1:0]            cls_irq;
    logic [NUM_CLASSES-1:0][IDX_W-1:0] cls_vec;
    logic [NUM_CLASSES-1:0]            rearm;

    logic                 aligned, hit_pend, hit_mask, hit_vn, hit_vf;
    logic                 hit_ctrl, hit_cfg, hit_trig, known, rd, wr;
    logic [IDX_W-1:0]     cfg_idx;
    logic [NUM_LINES-1:0] rd_val;
    logic [NUM_LINES-1:0] ack_mask;

    // Purpose: decode the offset of the current access.
    always_comb begin
        aligned  = (req_addr[1:0] == 2'b00);
        hit_pend = (req_addr == OFS_PEND);
        hit_mask = (req_addr == OFS_MASK);
        hit_vn   = (req_addr == OFS_VEC_NORM);
        hit_vf   = (req_addr == OFS_VEC_FAST);
        hit_ctrl = (req_addr == OFS_CTRL);
        hit_trig = (req_addr == OFS_TRIG);
        hit_cfg  = aligned && (req_addr >= OFS_CFG_BASE) && (req_addr < OFS_TRIG);
        cfg_idx  = IDX_W'((req_addr - OFS_CFG_BASE) >> 2);
        known    = hit_pend || hit_mask || hit_vn || hit_vf || hit_ctrl || hit_cfg || hit_trig;
        rd       = req_valid && !req_write && known;
        wr       = req_valid && req_write && known;
    end

    // Purpose: select the read value for a decoded register.
    always_comb begin
        rd_val = '0;
        if (hit_pend)      rd_val = pending;
        else if (hit_mask) rd_val = mask_q;
        else if (hit_vn)   rd_val = NUM_LINES'(cls_vec[CLS_NORMAL]);
        else if (hit_vf)   rd_val = NUM_LINES'(cls_vec[CLS_FAST]);
        else if (hit_cfg)  rd_val = NUM_LINES'({prio_q[cfg_idx*PRIO_W +: PRIO_W],
                                                level_q[cfg_idx], fast_q[cfg_idx]});
    end

    // Purpose: vector reads acknowledge their line when it is edge-sensitive.
    always_comb begin
        ack_mask = '0;
        if (rd && hit_vn && !level_q[cls_vec[CLS_NORMAL]])
            ack_mask = NUM_LINES'(1) << cls_vec[CLS_NORMAL];
        if (rd && hit_vf && !level_q[cls_vec[CLS_FAST]])
            ack_mask = ack_mask | (NUM_LINES'(1) << cls_vec[CLS_FAST]);
    end

    // Purpose: control-register write bits re-arm the matching class.
    always_comb begin
        for (int c = 0; c < NUM_CLASSES; c++)
            rearm[c] = wr && hit_ctrl && req_wdata[c];
    end

    // Purpose: registered response data and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_rdata <= rd ? rd_val : '0;
            rsp_err   <= req_valid && !known;
        end
    end

    // Purpose: mask and per-line configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            level_q <= '0;
            fast_q  <= '0;
            prio_q  <= '0;
        end else if (wr) begin
            if (hit_mask) mask_q <= req_wdata;
            if (hit_cfg) begin
                prio_q[cfg_idx*PRIO_W +: PRIO_W] <= req_wdata[PRIO_W+1:2];
                level_q[cfg_idx] <= req_wdata[1];
                fast_q[cfg_idx]  <= req_wdata[0];
            end
        end
    end

    intc_line_capture #(.NUM_LINES(NUM_LINES)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in      (irq_in),
        .level_i     (level_q),
        .pend_wr_i   (wr && hit_pend),
        .pend_wdata_i(req_wdata),
        .ack_mask_i  (ack_mask),
        .trig_i      (wr && hit_trig),
        .trig_bits_i (req_wdata),
        .pending_o   (pending)
    );

    intc_prio_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arbiter (
        .pending_i(pending),
        .mask_i   (mask_q),
        .fast_i   (fast_q),
        .prio_i   (prio_q),
        .any_o    (arb_any),
        .idx_o    (arb_idx)
    );

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
        intc_class_ctrl #(.IDX_W(IDX_W)) u_cls (
            .clk       (clk),
            .rst_n     (rst_n),
            .rearm_i   (rearm[c]),
            .cand_any_i(arb_any[c]),
            .cand_idx_i(arb_idx[c]),
            .irq_o     (cls_irq[c]),
            .vec_o     (cls_vec[c])
        );
    end

    assign irq_norm_o = cls_irq[CLS_NORMAL];
    assign irq_fast_o = cls_irq[CLS_FAST];

    // R11: an error pulse follows an access and carries zero data.
    p_err_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $past(req_valid));
    p_err_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));

    // R6: the normal winner is an unmasked pending normal-class line.
    p_norm_winner_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arb_any[CLS_NORMAL] |-> (pending[arb_idx[CLS_NORMAL]] && !mask_q[arb_idx[CLS_NORMAL]]
                                 && !fast_q[arb_idx[CLS_NORMAL]]));

    // R10: the fast winner is an unmasked pending fast-class line.
    p_fast_winner_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        arb_any[CLS_FAST] |-> (pending[arb_idx[CLS_FAST]] && !mask_q[arb_idx[CLS_FAST]]
                               && fast_q[arb_idx[CLS_FAST]]));
endmodule

// File: tb/irq_bank_ctrl_bench.sv
module irq_bank_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        irq_norm_o;
    logic        irq_fast_o;

    int checks = 0;
    int fails = 0;
    logic done = 1'b0;
    logic [31:0] rv;
    logic        ev;

    always #5 clk = ~clk;

    irq_bank_ctrl u_irq_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
    );

    // Table entry layout: {write, addr, wdata, expected read, expected error}.
    localparam int NTBL = 18;
    localparam logic [73:0] TBL [NTBL] = '{
        {1'b1, 8'h28, 32'h0000007F, 32'h0, 1'b0},         // R5 line 3 config
        {1'b0, 8'h28, 32'h0, 32'h0000007F, 1'b0},         // R5 readback
        {1'b1, 8'h98, 32'hFFFFFFFF, 32'h0, 1'b0},         // R5 line 31
        {1'b0, 8'h98, 32'h0, 32'h0000007F, 1'b0},         // R5 upper bits dropped
        {1'b1, 8'h28, 32'h0, 32'h0, 1'b0},
        {1'b1, 8'h98, 32'h0, 32'h0, 1'b0},
        {1'b0, 8'h28, 32'h0, 32'h0, 1'b0},                // R5 cleared
        {1'b0, 8'h18, 32'h0, 32'h0, 1'b0},                // R9 control reads 0
        {1'b0, 8'h9C, 32'h0, 32'h0, 1'b0},                // R9 trigger reads 0
        {1'b1, 8'h04, 32'h12345678, 32'h0, 1'b0},         // R10 mask write
        {1'b0, 8'h04, 32'h0, 32'h12345678, 1'b0},         // R10 mask readback
        {1'b1, 8'h04, 32'hFFFFFFFF, 32'h0, 1'b0},
        {1'b0, 8'h08, 32'h0, 32'h0, 1'b1},                // R11 undefined read
        {1'b0, 8'hA0, 32'h0, 32'h0, 1'b1},                // R11 beyond map
        {1'b0, 8'h2A, 32'h0, 32'h0, 1'b1},                // R11 misaligned
        {1'b1, 8'h0C, 32'h00000005, 32'h0, 1'b1},         // R11 undefined write
        {1'b1, 8'h10, 32'h00000007, 32'h0, 1'b0},         // R11 vector write ignored
        {1'b0, 8'h10, 32'h0, 32'h0, 1'b0}                 // R11 vector unchanged
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        rv = rsp_rdata; ev = rsp_err;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // Reset state (R1)
        idle(3);
        rst_n = 1'b1;
        chk("R1 norm out", {31'b0, irq_norm_o}, 32'h0);
        chk("R1 fast out", {31'b0, irq_fast_o}, 32'h0);
        bus(1'b0, 8'h04, 0); chk("R1 mask", rv, 32'hFFFFFFFF);
        bus(1'b0, 8'h00, 0); chk("R1 pending", rv, 32'h0);
        bus(1'b0, 8'h98, 0); chk("R1 config", rv, 32'h0);

        // Table of register accesses
        for (int i = 0; i < NTBL; i++) begin
            logic [73:0] e;
            e = TBL[i];
            bus(e[73], e[72:65], e[64:33]);
            if (!e[73]) chk($sformatf("R5/R9/R10/R11 table %0d data", i), rv, e[32:1]);
            chk($sformatf("R11 table %0d err", i), {31'b0, ev}, {31'b0, e[0]});
        end
        idle(1);
        chk("R11 err one cycle", {31'b0, rsp_err}, 32'h0);

        // Edge capture (R2)
        irq_in[4] = 1'b1;
        bus(1'b0, 8'h00, 0); chk("R2 edge captured", rv, 32'h10);
        bus(1'b1, 8'h00, 32'h0);
        idle(2);
        bus(1'b0, 8'h00, 0); chk("R2 no recapture while high", rv, 32'h0);
        irq_in[4] = 1'b0; idle(1); irq_in[4] = 1'b1;
        bus(1'b0, 8'h00, 0); chk("R2 new edge", rv, 32'h10);
        irq_in[4] = 1'b0; idle(2);
        bus(1'b0, 8'h00, 0); chk("R2 kept after fall", rv, 32'h10);

        // Level capture and AND write (R3, R4)
        bus(1'b1, 8'h38, 32'h2);            // line 7 level, prio 0
        irq_in[7] = 1'b1;
        bus(1'b0, 8'h00, 0); chk("R3 level pending", rv, 32'h90);
        bus(1'b1, 8'h00, 32'h0);
        bus(1'b0, 8'h00, 0); chk("R4 active level kept", rv, 32'h80);
        irq_in[5] = 1'b1; idle(1);
        bus(1'b1, 8'h00, 32'hFFFFFFDF);
        bus(1'b0, 8'h00, 0); chk("R4 AND clears one bit", rv, 32'h80);
        irq_in[7] = 1'b0; idle(2);
        bus(1'b0, 8'h00, 0); chk("R3 level cleared on fall", rv, 32'h0);
        irq_in[5] = 1'b0;

        // Arbitration and re-arm sequence (R6, R7, R8)
        bus(1'b1, 8'h24, 32'h0C);           // line 2 prio 3
        bus(1'b1, 8'h40, 32'h04);           // line 9 prio 1
        bus(1'b1, 8'h4C, 32'h04);           // line 12 prio 1
        bus(1'b1, 8'h6C, 32'h01);           // line 20 prio 0 fast
        bus(1'b1, 8'h04, 32'hFFFFEDFB);
        irq_in = 32'h00001204;
        idle(3);
        chk("R7 normal fires", {31'b0, irq_norm_o}, 32'h1);
        chk("R7 fast quiet", {31'b0, irq_fast_o}, 32'h0);
        bus(1'b0, 8'h10, 0); chk("R6 tie to higher line", rv, 32'd12);
        bus(1'b0, 8'h00, 0); chk("R8 edge acked", rv, 32'h204);
        bus(1'b0, 8'h10, 0); chk("R7 vector held", rv, 32'd12);
        bus(1'b1, 8'h18, 32'h1);
        chk("R7 rearm drops", {31'b0, irq_norm_o}, 32'h0);
        idle(1);
        chk("R7 refires", {31'b0, irq_norm_o}, 32'h1);
        bus(1'b0, 8'h10, 0); chk("R6 lower prio value wins", rv, 32'd9);
        bus(1'b1, 8'h18, 32'h1); idle(1);
        bus(1'b0, 8'h10, 0); chk("R6 last candidate", rv, 32'd2);
        bus(1'b1, 8'h18, 32'h1); idle(3);
        chk("R7 nothing left", {31'b0, irq_norm_o}, 32'h0);
        irq_in = '0;

        // Mask and fast class (R10)
        irq_in[20] = 1'b1; idle(3);
        chk("R10 masked line silent", {31'b0, irq_fast_o}, 32'h0);
        bus(1'b1, 8'h04, 32'hFFEFEDFB); idle(1);
        chk("R10 unmask fires fast", {31'b0, irq_fast_o}, 32'h1);
        chk("R7 normal unaffected", {31'b0, irq_norm_o}, 32'h0);
        bus(1'b0, 8'h14, 0); chk("R6 fast vector", rv, 32'd20);
        bus(1'b1, 8'h18, 32'h2);
        chk("R7 fast rearm drops", {31'b0, irq_fast_o}, 32'h0);
        idle(2);
        chk("R8 fast acked no refire", {31'b0, irq_fast_o}, 32'h0);
        irq_in[20] = 1'b0;

        // Level line read is not acknowledged (R8)
        bus(1'b1, 8'h04, 32'hFFEFED7B);
        irq_in[7] = 1'b1; idle(3);
        chk("R8 level fires", {31'b0, irq_norm_o}, 32'h1);
        bus(1'b0, 8'h10, 0); chk("R8 level vector", rv, 32'd7);
        bus(1'b0, 8'h00, 0); chk("R8 level not acked", rv, 32'h80);
        bus(1'b1, 8'h18, 32'h1); idle(1);
        chk("R8 level refires", {31'b0, irq_norm_o}, 32'h1);
        irq_in[7] = 1'b0; idle(2);
        bus(1'b1, 8'h18, 32'h1); idle(2);
        chk("R7 quiet after level fall", {31'b0, irq_norm_o}, 32'h0);

        // Software trigger (R9)
        bus(1'b1, 8'h9C, 32'h00000A00);
        bus(1'b0, 8'h00, 0); chk("R9 lowest bit only", rv, 32'h200);
        idle(1);
        chk("R9 trigger fires", {31'b0, irq_norm_o}, 32'h1);
        bus(1'b0, 8'h10, 0); chk("R9 trigger vector", rv, 32'd9);
        bus(1'b1, 8'h18, 32'h1);

        // Mid-run reset (R1)
        bus(1'b1, 8'h04, 32'h0);
        bus(1'b1, 8'h28, 32'h7F);
        bus(1'b1, 8'h9C, 32'h1);
        idle(2);
        chk("R1 pre-reset fire", {31'b0, irq_norm_o}, 32'h1);
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        chk("R1 out after reset", {31'b0, irq_norm_o}, 32'h0);
        bus(1'b0, 8'h04, 0); chk("R1 mask after reset", rv, 32'hFFFFFFFF);
        bus(1'b0, 8'h28, 0); chk("R1 config after reset", rv, 32'h0);
        bus(1'b0, 8'h00, 0); chk("R1 pending after reset", rv, 32'h0);
        bus(1'b0, 8'h10, 0); chk("R1 vector after reset", rv, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule